// File: doc/BRIEF.md
# Shared GPIO Port with Peripheral Override

This block is a parallel digital I/O port of up to 16 pins, controlled through a small word-addressed register bus. Software sets a direction bit and an output latch bit for each pin, and reads the pin levels back after they pass through a two-flop synchroniser. Each pin can also be taken over by a peripheral. The peripheral supplies an enable, an output enable and output data for each bit. While it drives a bit, its output enable and data go to the pad, and the port's direction and latch values for that bit have no effect.

The synchronised pin levels are returned both to the register read path and to the peripheral. A bit is never passed to the peripheral while the port itself drives that pin, so the port's output cannot loop back into the peripheral. A mask parameter marks which bits exist. The other bits read as zero, cannot be written and never drive the pad.

The register bus has a single-cycle write strobe and combinational read data. Address 0 holds the direction bits, where a 1 means input. Address 1 is the pin-read address, and a write to it updates the output latch. Address 2 is the output latch. Address 3 is unused.

Top module: `gpio_share_port`

## Requirements
- R1: On a bit that the peripheral does not drive, direction bit 1 gives `pad_oe` 0 (input) and direction bit 0 gives `pad_oe` 1 (output). Address 0 (`bus_addr`=2'd0) reads back the direction bits and is written by `bus_wr`.
- R2: After reset the direction register equals the implemented-bit mask (all pins inputs), the latch is zero and `pad_oe` is zero.
- R3: A read of address 2 returns the latch contents, not the pin levels. A write to address 2 loads the latch.
- R4: A read of address 1 returns the synchronised pin levels. A write to address 1 loads the output latch in the same way as a write to address 2.
- R5: Where `per_en` and `per_oe` are both 1 on an implemented bit, `pad_oe` is 1 and `pad_out` equals `per_out`, whatever the direction and latch bits hold.
- R6: Where the peripheral is disabled, or enabled but not driving a bit, `pad_out` equals the latch bit and `pad_oe` is the inverse of the direction bit.
- R7: `per_in` carries the synchronised pin level on bits the port is not driving, and 0 on bits the port drives from its latch.
- R8: Unimplemented bits (mask bit 0) read as 0 at every address and ignore writes. Their `pad_out`, `pad_oe` and `per_in` are 0.
- R9: Address 3 reads as zero, and a write to it changes no register.
- R10: A change on `pad_in` appears at the address 1 read data and at `per_in` after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register word address |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Combinational read data |
| per_en | input | W | Peripheral enable per bit |
| per_oe | input | W | Peripheral output enable per bit |
| per_out | input | W | Peripheral output data per bit |
| per_in | output | W | Synchronised pin level returned to the peripheral |
| pad_in | input | W | Raw pin level from the pad |
| pad_out | output | W | Output data to the pad |
| pad_oe | output | W | Output enable to the pad |

## Verification
The bench builds the port at the full width of 16 with mask 16'hBF7E, so bits 0, 7 and 14 are absent. With these holes, the zero-read, write-blocking and pad-silencing rules for missing bits can be checked next to live neighbours at both ends and in the middle of the word. Random per-bit mixes of peripheral enable and output enable put owned, port-driven and input bits side by side every cycle. The raw pad levels change freely, so the two-edge synchroniser delay is exposed at both the port read and the peripheral input.

// File: rtl/gpio_share_port.sv
module gpio_share_port #(
  parameter int W = 16,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   bus_addr,
  input  logic         bus_wr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] per_en,
  input  logic [W-1:0] per_oe,
  input  logic [W-1:0] per_out,
  output logic [W-1:0] per_in,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  localparam logic [1:0] A_DIR = 2'd0;
  localparam logic [1:0] A_PIN = 2'd1;
  localparam logic [1:0] A_LAT = 2'd2;

  logic [W-1:0] dir_q, lat_q, meta_q, sync_q;
  logic [W-1:0] own, port_drv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= MASK;
      lat_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_DIR) dir_q <= bus_wdata & MASK;
      if (bus_addr == A_PIN || bus_addr == A_LAT) lat_q <= bus_wdata & MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pad_in & MASK;
      sync_q <= meta_q;
    end
  end

  assign own      = per_en & per_oe & MASK;
  assign port_drv = ~own & ~dir_q & MASK;
  assign pad_oe   = own | port_drv;
  assign pad_out  = ((own & per_out) | (~own & lat_q)) & MASK;
  assign per_in   = sync_q & ~port_drv;

  always_comb begin
    case (bus_addr)
      A_DIR:   bus_rdata = dir_q;
      A_PIN:   bus_rdata = sync_q;
      A_LAT:   bus_rdata = lat_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_share_port_chk.sv
module gpio_share_port_chk #(
  parameter int W = 16,
  parameter logic [W-1:0] MASK = '1
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   bus_addr,
  input logic         bus_wr,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] bus_rdata,
  input logic [W-1:0] per_en,
  input logic [W-1:0] per_oe,
  input logic [W-1:0] per_out,
  input logic [W-1:0] per_in,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] lat_q
);
  p_owned_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((per_en & per_oe & MASK) & ~pad_oe) == '0);

  p_owned_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((per_en & per_oe & MASK) & (pad_out ^ per_out)) == '0);

  p_no_loop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (per_in & pad_oe & ~(per_en & per_oe)) == '0);

  p_unimpl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rdata | pad_out | pad_oe | per_in) & ~MASK) == '0);

  p_latch_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == 2'd1 || bus_addr == 2'd2)) |=> lat_q == ($past(bus_wdata) & MASK));
endmodule

bind gpio_share_port gpio_share_port_chk #(.W(W), .MASK(MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .per_en(per_en),
  .per_oe(per_oe), .per_out(per_out), .per_in(per_in),
  .pad_out(pad_out), .pad_oe(pad_oe), .lat_q(lat_q)
);

// File: tb/test_gpio_share_port.sv
module test_gpio_share_port;
  localparam int W = 16;
  localparam logic [W-1:0] MASK = 16'hBF7E;

  logic clk = 0, rst_n = 0;
  logic [1:0] bus_addr = 0;
  logic bus_wr = 0;
  logic [W-1:0] bus_wdata = 0, per_en = 0, per_oe = 0, per_out = 0, pad_in = 0;
  logic [W-1:0] bus_rdata, per_in, pad_out, pad_oe;

  gpio_share_port #(.W(W), .MASK(MASK)) i_gpio_share_port (.*);

  always #4 clk = ~clk;

  logic [W-1:0] m_dir, m_lat, m_s1, m_s2;
  int vectors = 0, miscompares = 0;
  bit done = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = MASK; m_lat = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      m_s2 = m_s1;
      m_s1 = pad_in & MASK;
      if (bus_wr && bus_addr == 0) m_dir = bus_wdata & MASK;
      if (bus_wr && (bus_addr == 1 || bus_addr == 2)) m_lat = bus_wdata & MASK;
    end
  end

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [W-1:0] own, drv, e_rd;
    own = per_en & per_oe & MASK;
    drv = ~own & ~m_dir & MASK;
    case (bus_addr)
      2'd0: e_rd = m_dir;
      2'd1: e_rd = m_s2;
      2'd2: e_rd = m_lat;
      default: e_rd = 0;
    endcase
    case (bus_addr)
      2'd0: chk("R1 rdata dir", bus_rdata, e_rd);
      2'd1: chk("R4/R10 rdata pin", bus_rdata, e_rd);
      2'd2: chk("R3 rdata latch", bus_rdata, e_rd);
      default: chk("R9 rdata unused", bus_rdata, e_rd);
    endcase
    chk("R5/R6 pad_oe", pad_oe, own | drv);
    chk("R5/R6 pad_out", pad_out, ((own & per_out) | (~own & m_lat)) & MASK);
    chk("R7/R10 per_in", per_in, m_s2 & ~drv);
    chk("R8 unimpl bits", (bus_rdata | pad_out | pad_oe | per_in) & ~MASK, '0);
  endtask

  task automatic step(logic [1:0] a, logic w, logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_wdata = d;
    #2 compare_all();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #20 rst_n = 1;
    // R2: reset state
    step(2'd0, 0, 0);
    chk("R2 dir after reset", bus_rdata, MASK);
    chk("R2 pad_oe after reset", pad_oe, '0);
    step(2'd2, 0, 0);
    chk("R2 latch after reset", bus_rdata, '0);
    // R1 / R8: direction writes, incl. unimplemented bits
    step(2'd0, 1, 16'h0000);
    step(2'd0, 0, 0);
    chk("R8 dir unimpl stays zero", bus_rdata, '0);
    step(2'd0, 1, 16'hFF00);
    // R4: latch through pin address; R3: latch address
    step(2'd1, 1, 16'hFFFF);
    step(2'd2, 0, 0);
    chk("R4 pin-address write reaches latch", bus_rdata, MASK);
    step(2'd2, 1, 16'h1234);
    // R9: unused address write ignored
    step(2'd3, 1, 16'hFFFF);
    step(2'd2, 0, 0);
    chk("R9 latch untouched", bus_rdata, 16'h1234 & MASK);
    step(2'd0, 0, 0);
    chk("R9 dir untouched", bus_rdata, 16'hFF00 & MASK);
    // R10: synchroniser latency
    pad_in = 16'hFFFF;
    step(2'd1, 0, 0);
    chk("R10 one edge: unchanged", bus_rdata, '0);
    step(2'd1, 0, 0);
    chk("R10 two edges: visible", bus_rdata, MASK);
    // R5: peripheral takes all bits
    per_en = 16'hFFFF; per_oe = 16'hFFFF; per_out = 16'hA5A5;
    step(2'd1, 0, 0);
    chk("R5 pad_out from peripheral", pad_out, 16'hA5A5 & MASK);
    // R6: enabled but not driving
    per_oe = 0;
    step(2'd2, 0, 0);
    chk("R6 pad_out from latch", pad_out, 16'h1234 & MASK);
    // random mix
    for (int i = 0; i < 2000; i++) begin
      per_en = W'($urandom); per_oe = W'($urandom);
      per_out = W'($urandom); pad_in = W'($urandom);
      step(2'($urandom), 1'($urandom_range(0, 3) == 0), W'($urandom));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule